// File: doc/BRIEF.md
# Remote Upgrade Image-Select Controller

This block chooses which configuration image a device pulls from its attached boot flash. The flash is divided into equal slots: slot 0 holds the protected factory image and slots 1 to `NUM_APP` hold application images. Out of reset the controller always starts a load of the factory image. Once the configuration engine reports success, the device is in user mode.

While in user mode, user logic may request a switch to one of the application images by index. The controller tells the engine where to start loading by giving it a slot base address. If that load reports an error, or never finishes within a fixed cycle budget, the controller goes back to the factory image without help from any outside host.

A small set of status outputs shows which image is running, why the last load was started, and whether the last request named an index that does not exist.

Top module: `img_sel_ctrl`

## Requirements
- R1: In the first clock cycle after reset is released, `cfg_start` pulses with `cfg_addr` = 0 (factory slot). During and after reset, `last_cause` = 2'b00 (power-up), `cur_image` = 0, `user_mode` = 0 and `index_err` = 0. `user_mode` stays 0 until the engine reports completion.
- R2: `cfg_start` is a single-cycle pulse. `cfg_addr` equals the target index multiplied by 2^`SLOT_LOG2` and is held until the next pulse.
- R3: When `cfg_done` is high with `cfg_err` low during a load, `user_mode` rises on the next clock edge and `cur_image` becomes the index just loaded. `cur_image` is unchanged while a load is in progress.
- R4: In user mode, a request with an index from 1 to `NUM_APP` drops `user_mode` and sets `last_cause` to 2'b01 (user) on the next edge. `cfg_start` pulses one cycle after that, carrying the slot address of that index.
- R5: In user mode, a request with index 0 or an index above `NUM_APP` starts no load. `user_mode` and `cur_image` are left unchanged and `index_err` is set. An accepted request clears `index_err`.
- R6: A load that ends with `cfg_done` and `cfg_err` both high causes a factory load (address 0) and sets `last_cause` to 2'b10 (fallback).
- R7: A load that sees no `cfg_done` within `LOAD_TIMEOUT` cycles is treated as a failed load and falls back exactly as in R6.
- R8: Requests that arrive while a load is in progress are ignored.
- R9: A failed factory load retries the factory image, with `last_cause` = 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_req | input | 1 | One-cycle request to reconfigure |
| usr_index | input | IDX_W | Requested application index |
| cfg_start | output | 1 | Start pulse to the configuration engine |
| cfg_addr | output | ADDR_W | Flash base address of the image to load |
| cfg_done | input | 1 | Engine reports end of load |
| cfg_err | input | 1 | Qualifies `cfg_done` as a failed load |
| user_mode | output | 1 | A loaded image is running |
| cur_image | output | IDX_W | Index of the image running |
| last_cause | output | 2 | Reason for the last load: 00 power-up, 01 user, 10 fallback |
| index_err | output | 1 | Last request named an absent image |

## Verification
The bench builds the block with `NUM_APP` = 5 and a 3-bit index, so index 0, indices 6 and 7, and the top valid index 5 can all be requested. It uses `SLOT_LOG2` = 12, which makes slot addresses easy to read. `LOAD_TIMEOUT` is set to 16, so the watchdog fallback is reached in a few dozen cycles. Using this sizing, a scoreboard of expected start addresses checks every power-up, user, error and timeout load, as well as a repeated factory retry.

// File: rtl/img_sel_pkg.sv
package img_sel_pkg;

    typedef enum logic [1:0] {
        ST_KICK = 2'b00,
        ST_LOAD = 2'b01,
        ST_RUN  = 2'b10
    } ise_state_e;

    typedef enum logic [1:0] {
        CAUSE_POWERUP  = 2'b00,
        CAUSE_USER     = 2'b01,
        CAUSE_FALLBACK = 2'b10
    } ise_cause_e;

endpackage

// File: rtl/img_sel_idx_chk.sv
module img_sel_idx_chk #(
    parameter int NUM_APP = 3,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0] idx,
    output logic             valid
);
    localparam logic [IDX_W:0] MAX_IDX = (IDX_W+1)'(NUM_APP);

    always_comb begin
        valid = (idx != '0) && ({1'b0, idx} <= MAX_IDX);
    end
endmodule

// File: rtl/img_sel_slot_map.sv
module img_sel_slot_map #(
    parameter int IDX_W     = 2,
    parameter int ADDR_W    = 24,
    parameter int SLOT_LOG2 = 20
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = ADDR_W'(idx) << SLOT_LOG2;
    end
endmodule

// File: rtl/img_sel_load_timer.sv
module img_sel_load_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
        expired = run && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/img_sel_ctrl.sv
module img_sel_ctrl
    import img_sel_pkg::*;
#(
    parameter int NUM_APP      = 3,
    parameter int IDX_W        = 2,
    parameter int ADDR_W       = 24,
    parameter int SLOT_LOG2    = 20,
    parameter int LOAD_TIMEOUT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_req,
    input  logic [IDX_W-1:0]  usr_index,
    output logic              cfg_start,
    output logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_done,
    input  logic              cfg_err,
    output logic              user_mode,
    output logic [IDX_W-1:0]  cur_image,
    output logic [1:0]        last_cause,
    output logic              index_err
);
    typedef struct packed {
        ise_state_e        st;
        logic              start;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  tgt;
        logic [IDX_W-1:0]  cur;
        ise_cause_e        cause;
        logic              bad;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic              idx_ok;
    logic [ADDR_W-1:0] tgt_addr;
    logic              tmo;
    logic              loading;

    assign loading = (r_q.st == ST_LOAD);

    img_sel_idx_chk #(.NUM_APP(NUM_APP), .IDX_W(IDX_W)) u_idx_chk (
        .idx   (usr_index),
        .valid (idx_ok)
    );

    img_sel_slot_map #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .SLOT_LOG2(SLOT_LOG2)) u_slot_map (
        .idx  (r_q.tgt),
        .addr (tgt_addr)
    );

    img_sel_load_timer #(.LIMIT(LOAD_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (loading),
        .expired (tmo)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        case (r_q.st)
            ST_KICK: begin
                r_d.start = 1'b1;
                r_d.addr  = tgt_addr;
                r_d.st    = ST_LOAD;
            end
            ST_LOAD: begin
                if (cfg_done && !cfg_err) begin
                    r_d.cur = r_q.tgt;
                    r_d.st  = ST_RUN;
                end else if ((cfg_done && cfg_err) || tmo) begin
                    r_d.tgt   = '0;
                    r_d.cause = CAUSE_FALLBACK;
                    r_d.st    = ST_KICK;
                end
            end
            ST_RUN: begin
                if (usr_req) begin
                    if (idx_ok) begin
                        r_d.tgt   = usr_index;
                        r_d.cause = CAUSE_USER;
                        r_d.bad   = 1'b0;
                        r_d.st    = ST_KICK;
                    end else begin
                        r_d.bad = 1'b1;
                    end
                end
            end
            default: begin
                r_d.tgt = '0;
                r_d.st  = ST_KICK;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_KICK;
            r_q.start <= 1'b0;
            r_q.addr  <= '0;
            r_q.tgt   <= '0;
            r_q.cur   <= '0;
            r_q.cause <= CAUSE_POWERUP;
            r_q.bad   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_start  = r_q.start;
    assign cfg_addr   = r_q.addr;
    assign user_mode  = (r_q.st == ST_RUN);
    assign cur_image  = r_q.cur;
    assign last_cause = r_q.cause;
    assign index_err  = r_q.bad;
endmodule

// File: rtl/img_sel_ctrl_chk.sv
module img_sel_ctrl_chk #(
    parameter int NUM_APP      = 3,
    parameter int IDX_W        = 2,
    parameter int ADDR_W       = 24,
    parameter int SLOT_LOG2    = 20,
    parameter int LOAD_TIMEOUT = 1000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usr_req,
    input logic [IDX_W-1:0]  usr_index,
    input logic              cfg_start,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_done,
    input logic              cfg_err,
    input logic              user_mode,
    input logic [IDX_W-1:0]  cur_image,
    input logic [1:0]        last_cause,
    input logic              index_err
);
    localparam logic [IDX_W:0] TOP_IDX = (IDX_W+1)'(NUM_APP);

    logic bad_idx;
    assign bad_idx = (usr_index == '0) || ({1'b0, usr_index} > TOP_IDX);

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_start);

    // R1
    start_not_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |-> !user_mode);

    // R3
    done_enters_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && cfg_done && !cfg_err) |=> user_mode);

    // R4
    good_req_leaves_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && usr_req && !bad_idx) |=> (!user_mode && last_cause == 2'b01));

    // R5
    bad_req_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && usr_req && bad_idx) |=> (user_mode && index_err && $stable(cur_image)));

    // R6
    err_sets_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && cfg_done && cfg_err) |=> (last_cause == 2'b10));

    // R6
    fallback_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && last_cause == 2'b10) |-> (cfg_addr == '0));
endmodule

bind img_sel_ctrl img_sel_ctrl_chk #(
    .NUM_APP(NUM_APP), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .SLOT_LOG2(SLOT_LOG2), .LOAD_TIMEOUT(LOAD_TIMEOUT)
) u_chk (.*);

// File: tb/img_sel_ctrl_bench.sv
module img_sel_ctrl_bench;
    localparam int NAPP = 5;
    localparam int IW   = 3;
    localparam int AW   = 16;
    localparam int SL   = 12;
    localparam int TMO  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usr_req = 1'b0;
    logic [IW-1:0] usr_index = '0;
    logic          cfg_done = 1'b0;
    logic          cfg_err = 1'b0;
    logic          cfg_start;
    logic [AW-1:0] cfg_addr;
    logic          user_mode;
    logic [IW-1:0] cur_image;
    logic [1:0]    last_cause;
    logic          index_err;

    int errs = 0;
    int checks = 0;
    bit done_all = 1'b0;
    logic [AW-1:0] exp_q[$];

    always #4 clk = ~clk;

    img_sel_ctrl #(.NUM_APP(NAPP), .IDX_W(IW), .ADDR_W(AW), .SLOT_LOG2(SL), .LOAD_TIMEOUT(TMO))
    u_img_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_index(usr_index),
        .cfg_start(cfg_start), .cfg_addr(cfg_addr), .cfg_done(cfg_done), .cfg_err(cfg_err),
        .user_mode(user_mode), .cur_image(cur_image), .last_cause(last_cause), .index_err(index_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_start(input logic [IW-1:0] idx);
        exp_q.push_back(AW'(idx) << SL);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trigger(input logic [IW-1:0] idx);
        @(negedge clk);
        usr_req = 1'b1;
        usr_index = idx;
        @(negedge clk);
        usr_req = 1'b0;
    endtask

    task automatic engine_end(input logic bad);
        @(negedge clk);
        cfg_done = 1'b1;
        cfg_err = bad;
        @(negedge clk);
        cfg_done = 1'b0;
        cfg_err = 1'b0;
    endtask

    // monitor: every start pulse must match the next expected address
    always @(negedge clk) begin
        if (rst_n && cfg_start) begin
            if (exp_q.size() == 0) begin
                chk("R5 R8 unexpected start pulse", 32'(cfg_addr), 32'hFFFF_FFFF);
            end else begin
                chk("R2 start address", 32'(cfg_addr), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_all) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        cycles(4);
        chk("R1 reset start", 32'(cfg_start), 0);
        chk("R1 reset user_mode", 32'(user_mode), 0);
        chk("R1 reset cur_image", 32'(cur_image), 0);
        chk("R1 reset cause", 32'(last_cause), 0);
        chk("R1 reset index_err", 32'(index_err), 0);
        expect_start(0);
        rst_n = 1'b1;
        cycles(3);
        chk("R1 boot start seen", 32'(exp_q.size()), 0);
        chk("R1 waiting for engine", 32'(user_mode), 0);
        engine_end(1'b0);
        chk("R3 factory running", 32'(user_mode), 1);
        chk("R3 factory index", 32'(cur_image), 0);
        chk("R1 cause power-up", 32'(last_cause), 0);

        // R4: user switch to image 2
        expect_start(2);
        trigger(2);
        chk("R4 user_mode dropped", 32'(user_mode), 0);
        chk("R4 cause user", 32'(last_cause), 1);
        chk("R3 cur unchanged during load", 32'(cur_image), 0);
        cycles(3);
        engine_end(1'b0);
        chk("R3 running image 2", 32'(cur_image), 2);
        chk("R3 user_mode back", 32'(user_mode), 1);

        // R5: absent indices
        trigger(7);
        chk("R5 index_err set (7)", 32'(index_err), 1);
        chk("R5 user_mode kept (7)", 32'(user_mode), 1);
        cycles(4);
        chk("R5 cur kept (7)", 32'(cur_image), 2);
        trigger(0);
        chk("R5 index_err set (0)", 32'(index_err), 1);
        chk("R5 user_mode kept (0)", 32'(user_mode), 1);
        cycles(4);

        // R6: top index fails to load
        expect_start(5);
        expect_start(0);
        trigger(5);
        chk("R5 index_err cleared", 32'(index_err), 0);
        cycles(3);
        engine_end(1'b1);
        cycles(3);
        chk("R6 fallback start seen", 32'(exp_q.size()), 0);
        chk("R6 cause fallback", 32'(last_cause), 2);
        engine_end(1'b0);
        chk("R6 factory running", 32'(cur_image), 0);

        // R7: load never finishes; R8: request during load ignored
        expect_start(1);
        expect_start(0);
        trigger(1);
        cycles(2);
        trigger(3);
        chk("R8 still loading", 32'(user_mode), 0);
        cycles(TMO + 6);
        chk("R7 timeout fallback seen", 32'(exp_q.size()), 0);
        chk("R7 cause fallback", 32'(last_cause), 2);
        engine_end(1'b0);
        chk("R7 factory running", 32'(cur_image), 0);

        // R9: factory retry after failure
        expect_start(4);
        expect_start(0);
        expect_start(0);
        trigger(4);
        cycles(3);
        engine_end(1'b1);
        cycles(3);
        engine_end(1'b1);
        cycles(3);
        chk("R9 factory retried", 32'(exp_q.size()), 0);
        chk("R9 cause fallback", 32'(last_cause), 2);
        engine_end(1'b0);
        chk("R9 factory running", 32'(user_mode), 1);
        chk("R9 factory index", 32'(cur_image), 0);

        cycles(4);
        chk("R2 no stray starts", 32'(exp_q.size()), 0);
        done_all = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule